// File: doc/BRIEF.md
# 64-bit Timestamp Counter with Snapshot and Preset

This block keeps a free-running 64-bit timestamp that advances once every N+1 clocks. N comes from a divider field in a control register. Software sees the block as seven 32-bit registers on a simple bus: one write strobe, a word address and a combinational read data path. Reading the live count takes two bus accesses, and the count can move between them.

Software reads a coherent value in two steps. It first writes a snapshot command to the control register, which copies all 64 bits into a shadow pair in one clock. It then reads the shadow words at leisure: high word first, then low. The shadow pair keeps its value until the next snapshot command.

To preset the count, software writes the wanted value into a pair of load registers. It then issues a load command through a different bit combination in the same control register.

Top module: `ts64_timestamp`

## Requirements
- R1: After reset every readable register returns 0 and the counter does not advance.
- R2: The register map is: control at 0x68, live low word 0x6C, live high word 0x70, load low word 0x74, load high word 0x78, shadow low word 0x7C, shadow high word 0x80. Any other address reads as 0.
- R3: In the control register, bit 0 is the run enable and reads back as written. Bits [31:16] are the divider N and read back as written. Bit 1 always reads 0, and so do all other bits.
- R4: While run is set, the counter increments once every N+1 clocks. After run was clear, the first increment comes N+1 clocks after the edge that sets run.
- R5: The counter is 64 bits wide. It carries from the low word into the high word and wraps from all ones to 0.
- R6: A control write with bit 0 = 1 and bit 1 = 0 copies, at that clock edge, the count held just before the edge into the shadow pair. The shadow pair then stays unchanged until the next such write.
- R7: A control write with bit 0 = 1 and bit 1 = 1 sets the counter to the load pair at that edge and does not change the shadow pair.
- R8: The load low and high words can be read and written, and they reset to 0.
- R9: When a load command and an increment fall on the same edge, the counter takes the loaded value L. It shows L+1 after the next increment.
- R10: Writes to the live and shadow addresses change neither the counter nor the shadow pair.
- R11: A control write with bit 1 = 1 and bit 0 = 0 performs neither a load nor a snapshot, and it stops the counter.
- R12: Clearing bit 0 freezes the count at its value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for counting and for the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The count is started with divider 0 from a preset just below 2^64, which shows single-step counting and the wrap to 0. It is then preset just below a 32-bit boundary with divider 3, and sampled on every clock, which shows the exact tick spacing and the carry into the high word. A snapshot taken while running must equal the count of the clock before the command, and it must not move as the live count keeps moving. Stray writes to read-only words, a load bit given without run, and a load landing on an increment edge each leave a result that differs from the effect a faulty decode or a faulty priority would have.

// File: rtl/ts64_pkg.sv
// Package: register map, control bit positions and address decode shared by
// the timestamp counter. Assumes an 8-bit byte address and 32-bit words.
package ts64_pkg;

    localparam int REG_ADDR_W = 8;
    typedef logic [REG_ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t A_CTRL    = 8'h68;
    localparam reg_addr_t A_LIVE_LO = 8'h6C;
    localparam reg_addr_t A_LIVE_HI = 8'h70;
    localparam reg_addr_t A_LOAD_LO = 8'h74;
    localparam reg_addr_t A_LOAD_HI = 8'h78;
    localparam reg_addr_t A_SNAP_LO = 8'h7C;
    localparam reg_addr_t A_SNAP_HI = 8'h80;

    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_LOAD_BIT = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LIVE,
        SEL_LOAD,
        SEL_SNAP
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     hi;
    } reg_dec_t;

    // Map a byte address to a register group and a word half.
    function automatic reg_dec_t decode(input reg_addr_t a);
        reg_dec_t d;
        d = '{sel: SEL_NONE, hi: 1'b0};
        case (a)
            A_CTRL:    d = '{sel: SEL_CTRL, hi: 1'b0};
            A_LIVE_LO: d = '{sel: SEL_LIVE, hi: 1'b0};
            A_LIVE_HI: d = '{sel: SEL_LIVE, hi: 1'b1};
            A_LOAD_LO: d = '{sel: SEL_LOAD, hi: 1'b0};
            A_LOAD_HI: d = '{sel: SEL_LOAD, hi: 1'b1};
            A_SNAP_LO: d = '{sel: SEL_SNAP, hi: 1'b0};
            A_SNAP_HI: d = '{sel: SEL_SNAP, hi: 1'b1};
            default:   d = '{sel: SEL_NONE, hi: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ts64_prescaler.sv
// Prescaler: gives one tick every DIV+1 clocks while run is high. It restarts
// from zero whenever run is low. A divider lowered on the fly takes effect at
// once: the compare is >=, so the phase cannot overshoot.
module ts64_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    // Tick when the phase has reached the divider.
    always_comb tick = run && (phase_q >= div);

    // Advance the phase, wrapping on a tick and clearing while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (!run)    phase_q <= '0;
        else if (tick)    phase_q <= '0;
        else              phase_q <= phase_q + 1'b1;
    end

    // With a steady nonzero divider, two ticks never come back to back.
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && $past(run) && run && (div != '0) && $stable(div)) |-> !tick);

    // A stopped prescaler never ticks.
    assert_no_tick_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

endmodule

// File: rtl/ts64_core.sv
// Counter core: a CNT_W-bit count that steps on tick and wraps at 2^CNT_W.
// A load takes priority over a tick that falls on the same edge.
module ts64_core #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);

    // Update the count: load first, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load_en) cnt <= load_val;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_en) |-> (cnt == $past(load_val)));

    assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_en) && $past(tick)) |-> (cnt == $past(cnt) + 1'b1));

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_en) && !$past(tick)) |-> $stable(cnt));

endmodule

// File: rtl/ts64_shadow.sv
// Shadow register: captures the whole count in one clock on snap and holds it
// until the next snap. Snap is a one-clock pulse.
module ts64_shadow #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap,
    input  logic [CNT_W-1:0] src,
    output logic [CNT_W-1:0] shadow
);

    // Capture the source on snap.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow <= '0;
        else if (snap) shadow <= src;
    end

    assert_snap_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(snap) |-> (shadow == $past(src)));

    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(snap) |-> $stable(shadow));

endmodule

// File: rtl/ts64_timestamp.sv
// Top: register decode for the 64-bit timestamp counter. Writes take effect on
// the strobe edge. Reads are combinational from addr. The counter is two bus
// words wide. Bit 0 of control is run; run with bit 1 set loads, run with
// bit 1 clear snapshots.
module ts64_timestamp #(
    parameter int BUS_W = 32,
    parameter int DIV_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ts64_pkg::REG_ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]              wdata,
    output logic [BUS_W-1:0]              rdata
);
    import ts64_pkg::*;

    localparam int CNT_W   = 2 * BUS_W;
    localparam int N_WORDS = CNT_W / BUS_W;
    localparam int DIV_LSB = BUS_W - DIV_W;

    reg_dec_t         dec;
    logic             ctrl_wr, snap, load_en, tick;
    logic             run_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] load_val, cnt, shadow;

    // Decode the address and split control writes into commands.
    always_comb begin
        dec     = decode(addr);
        ctrl_wr = wr_en && (dec.sel == SEL_CTRL);
        snap    = ctrl_wr && wdata[CTL_RUN_BIT] && !wdata[CTL_LOAD_BIT];
        load_en = ctrl_wr && wdata[CTL_RUN_BIT] &&  wdata[CTL_LOAD_BIT];
    end

    // Hold the run enable and the divider from the last control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= '0;
        end else if (ctrl_wr) begin
            run_q <= wdata[CTL_RUN_BIT];
            div_q <= wdata[DIV_LSB +: DIV_W];
        end
    end

    // One read/write load word per bus word of the counter.
    for (genvar w = 0; w < N_WORDS; w++) begin : g_load
        logic [BUS_W-1:0] word_q;
        // Store the load word addressed by this write.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else if (wr_en && (dec.sel == SEL_LOAD) && (dec.hi == 1'(w))) word_q <= wdata;
        end
        assign load_val[w*BUS_W +: BUS_W] = word_q;
    end

    ts64_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .div(div_q), .tick(tick)
    );

    ts64_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
        .load_val(load_val), .cnt(cnt)
    );

    ts64_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .snap(snap), .src(cnt), .shadow(shadow)
    );

    // Select the read word; unmapped addresses read as zero.
    always_comb begin
        rdata = '0;
        case (dec.sel)
            SEL_CTRL: begin
                rdata[DIV_LSB +: DIV_W] = div_q;
                rdata[CTL_RUN_BIT]      = run_q;
            end
            SEL_LIVE: rdata = dec.hi ? cnt[CNT_W-1:BUS_W]      : cnt[BUS_W-1:0];
            SEL_LOAD: rdata = dec.hi ? load_val[CNT_W-1:BUS_W] : load_val[BUS_W-1:0];
            SEL_SNAP: rdata = dec.hi ? shadow[CNT_W-1:BUS_W]   : shadow[BUS_W-1:0];
            default:  rdata = '0;
        endcase
    end

    assert_run_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_wr) |-> (run_q == $past(wdata[CTL_RUN_BIT])));

    assert_load_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(load_val));

    assert_ro_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(dec.sel) == SEL_SNAP)) |-> $stable(shadow));

    assert_cmd_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_wr) && !$past(wdata[CTL_RUN_BIT])) |-> $stable(shadow));

endmodule

// File: tb/ts64_timestamp_test.sv
// Scoreboard bench: reads push expected words into a queue, and a monitor pops
// them and compares them with rdata. Expected counts come from the edge index.
module ts64_timestamp_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    ts64_timestamp uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [7:0]  a;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     mon_ev;
    int       n_chk = 0;
    int       n_fail = 0;
    int       last_edge = 0;
    bit       done = 1'b0;

    // Monitor: pop the next expected item and compare it with rdata.
    always @(mon_ev) begin
        sb_item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
        end
    end

    task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_q.push_back('{a: a, exp: e, tag: tag});
        addr = a;
        #1;
        ->mon_ev;
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        last_edge = cyc;
        wr_en = 1'b0;
    endtask

    // Expected count after the current edge, given preset L at edge c0 and divider n.
    function automatic logic [63:0] cnt_at(input logic [63:0] l, input int c0, input int e, input int n);
        return l + 64'((e - c0) / (n + 1));
    endfunction

    task automatic chk_live(input logic [63:0] e, input string tag);
        chk(8'h6C, e[31:0], tag);
        chk(8'h70, e[63:32], tag);
    endtask

    task automatic chk_snap(input logic [63:0] e, input string tag);
        chk(8'h80, e[63:32], tag);
        chk(8'h7C, e[31:0], tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] l, snap_v, frozen;
        int c0, cs, n;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: reset values and unmapped address
        @(negedge clk);
        chk(8'h68, 32'h0, "R1 ctrl");
        chk_live(64'h0, "R1 live");
        chk(8'h74, 32'h0, "R1 R8 load lo");
        chk(8'h78, 32'h0, "R1 R8 load hi");
        chk_snap(64'h0, "R1 shadow");
        chk(8'h00, 32'h0, "R2 unmapped");
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_live(64'h0, "R1 stopped");

        // R8: load words read back
        l = 64'hFFFF_FFFF_FFFF_FFF0;
        wr(8'h74, l[31:0]);
        wr(8'h78, l[63:32]);
        @(negedge clk);
        chk(8'h74, l[31:0], "R8 load lo");
        chk(8'h78, l[63:32], "R8 load hi");

        // R7 R5: preset near 2^64, divider 0, watch the wrap
        n = 0;
        wr(8'h68, 32'h0000_0003);
        c0 = last_edge;
        @(negedge clk);
        chk_live(cnt_at(l, c0, cyc, n), "R7 preset");
        chk_snap(64'h0, "R7 no snapshot");
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk_live(cnt_at(l, c0, cyc, n), "R5 wrap");
        chk(8'h68, 32'h0000_0001, "R3 ctrl readback");

        // R12: stop freezes the count
        wr(8'h68, 32'h0);
        frozen = cnt_at(l, c0, last_edge, n);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk_live(frozen, "R12 frozen");

        // R4 R5: divider 3, preset below a word boundary
        l = 64'h0000_0001_FFFF_FFFE;
        n = 3;
        wr(8'h74, l[31:0]);
        wr(8'h78, l[63:32]);
        wr(8'h68, 32'h0003_0003);
        c0 = last_edge;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk_live(cnt_at(l, c0, cyc, n), "R4 R5 divided count");
        end
        chk(8'h68, 32'h0003_0001, "R3 divider readback");

        // R6: snapshot equals the count just before the command edge
        wr(8'h68, 32'h0003_0001);
        cs = last_edge;
        snap_v = cnt_at(l, c0, cs - 1, n);
        @(negedge clk);
        chk_snap(snap_v, "R6 capture");
        repeat (17) @(posedge clk);
        @(negedge clk);
        chk_snap(snap_v, "R6 hold");
        @(negedge clk);
        chk_live(cnt_at(l, c0, cyc, n), "R6 live moves on");

        // R10: writes to read-only words are ignored
        wr(8'h6C, 32'hDEAD_BEEF);
        wr(8'h70, 32'hDEAD_BEEF);
        wr(8'h7C, 32'h1234_5678);
        wr(8'h80, 32'h1234_5678);
        @(negedge clk);
        chk_live(cnt_at(l, c0, cyc, n), "R10 live");
        chk_snap(snap_v, "R10 shadow");

        // R11: load bit without run does nothing but stop
        wr(8'h68, 32'h0000_0002);
        frozen = cnt_at(l, c0, last_edge, n);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk_live(frozen, "R11 no load, stopped");
        chk_snap(snap_v, "R11 no snapshot");
        chk(8'h68, 32'h0, "R11 R3 ctrl bit1 reads 0");

        // R9: load on an increment edge
        wr(8'h68, 32'h0000_0001);
        l = 64'h0123_4567_89AB_CDEF;
        n = 0;
        wr(8'h74, l[31:0]);
        wr(8'h78, l[63:32]);
        wr(8'h68, 32'h0000_0003);
        c0 = last_edge;
        @(negedge clk);
        chk_live(l, "R9 load wins");
        @(negedge clk);
        chk_live(l + 64'd1, "R9 resumes");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule